// File: doc/BRIEF.md
# Floating-Point Load Selective Abort Unit

This unit sits next to the floating-point issue queue. It decides what happens to instructions that were issued speculatively behind a floating-point load. A load that hits delivers its data four cycles after it issues. The scheduler therefore lets consumers issue in the single cycle that sits `LOAD_LAT-1` cycles after the load, before the cache has said whether the load hit. The unit keeps track of that one-cycle window: it stores the load's destination register tag, and it compares the valid source tags of every instruction issued in the window against that tag.

One cycle after an instruction issues, the unit samples the data-cache miss indication and makes its decision. An instruction that read the load's destination is aborted when the load missed. Its queue entry is then flagged, on the cycle after the abort, as able to request issue again. Every other instruction is released from the queue at its normal time, whether or not the load missed. Only one load is tracked at a time: a newer load restarts the window timing and replaces the stored tag.

Top module: `fp_sel_abort`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after reset is released, `abort_o`, `retire_o` and `reissue_o` are all zero.
- R2: The speculative window is exactly the one cycle that comes `LOAD_LAT-1` cycles (3 by default) after the cycle in which `ld_issue_i` was sampled high. An instruction issued in any other cycle is never aborted.
- R3: When `ld_miss_i` is high in the cycle after the window, every instruction issued in the window with a valid source tag equal to the load's `ld_dst_i` has its `abort_o` bit high in that cycle.
- R4: An instruction issued in the window that reads no source equal to the load's destination gets `retire_o` in the cycle after issue, even when `ld_miss_i` is high.
- R5: When `ld_miss_i` is low in the cycle after the window, every instruction issued in the window retires, including dependent ones.
- R6: Each instruction has two source operands, index 0 and index 1 in `iss_src_i[k]`. A match on either one marks the instruction as dependent, and an operand whose bit in `iss_src_vld_i[k]` is 0 is never compared.
- R7: For each slot k, a valid issue in one cycle produces exactly one of `abort_o[k]` or `retire_o[k]` in the next cycle, with `out_id_o[k]` equal to the issued `iss_id_i[k]`. A slot that was not valid produces neither.
- R8: Bit `id` of `reissue_o` is high for exactly one cycle, the cycle after `abort_o[k]` was high with `out_id_o[k]` equal to `id`.
- R9: A load issued while an earlier one is still tracked cancels the earlier window. The window then follows the newer load's timing and compares against the newer load's tag.
- R10: `ld_miss_i` has no effect in any cycle that does not follow a window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ld_issue_i | input | 1 | A floating-point load issues this cycle |
| ld_dst_i | input | TAG_W | Destination register tag of the issuing load |
| ld_miss_i | input | 1 | Data cache miss for the tracked load, sampled in the cycle after the window |
| iss_vld_i | input | SLOTS | Per issue slot: an instruction issues this cycle |
| iss_id_i | input | SLOTS x ID_W | Queue entry index of each issued instruction |
| iss_src_i | input | SLOTS x 2 x TAG_W | Two source register tags per slot |
| iss_src_vld_i | input | SLOTS x 2 | Source tag valid bits per slot |
| abort_o | output | SLOTS | Instruction issued last cycle is aborted |
| retire_o | output | SLOTS | Instruction issued last cycle is released from the queue |
| out_id_o | output | SLOTS x ID_W | Queue entry index belonging to abort_o / retire_o |
| reissue_o | output | ENTRIES | Queue entries that may request issue again this cycle |

## Verification
The checker watches several properties on every cycle. It checks that each issue is answered by exactly one outcome on the next cycle. It checks that an abort only occurs with a miss and only for an instruction that issued while the window was open. It checks that the window opens exactly `LOAD_LAT-1` cycles after the latest load, and that each reissue bit follows an abort. Whether the abort lands on the right instruction, however, can only be shown by the bench's scenarios. Those scenarios cover matches on one operand versus the other, operands marked invalid, a miss pulse outside a window, and a newer load replacing the tracked tag.

// File: rtl/fp_sa_pkg.sv
package fp_sa_pkg;
  localparam int unsigned NUM_SRC = 2;

  typedef enum logic {
    TRK_IDLE = 1'b0,
    TRK_WAIT = 1'b1
  } trk_state_e;
endpackage

// File: rtl/fp_sa_tracker.sv
module fp_sa_tracker #(
  parameter int unsigned TAG_W    = 6,
  parameter int unsigned LOAD_LAT = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_issue_i,
  input  logic [TAG_W-1:0] ld_dst_i,
  output logic             win_open_o,
  output logic [TAG_W-1:0] win_tag_o
);
  import fp_sa_pkg::*;

  localparam int unsigned AGE_W = $clog2(LOAD_LAT + 1);
  localparam logic [AGE_W-1:0] WIN_AGE = AGE_W'(LOAD_LAT - 1);

  trk_state_e       state_q;
  logic [AGE_W-1:0] age_q;
  logic [TAG_W-1:0] tag_q;

  assign win_open_o = (state_q == TRK_WAIT) && (age_q == WIN_AGE);
  assign win_tag_o  = tag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TRK_IDLE;
      age_q   <= '0;
      tag_q   <= '0;
    end else if (ld_issue_i) begin
      // newest load wins; restart timing
      state_q <= TRK_WAIT;
      age_q   <= AGE_W'(1);
      tag_q   <= ld_dst_i;
    end else if (state_q == TRK_WAIT) begin
      if (age_q == WIN_AGE) begin
        state_q <= TRK_IDLE;
        age_q   <= '0;
      end else begin
        age_q <= age_q + AGE_W'(1);
      end
    end
  end
endmodule

// File: rtl/fp_sa_dep_match.sv
module fp_sa_dep_match #(
  parameter int unsigned SLOTS = 2,
  parameter int unsigned TAG_W = 6
) (
  input  logic                                      open_i,
  input  logic [TAG_W-1:0]                          tag_i,
  input  logic [SLOTS-1:0][fp_sa_pkg::NUM_SRC-1:0][TAG_W-1:0] src_i,
  input  logic [SLOTS-1:0][fp_sa_pkg::NUM_SRC-1:0]  src_vld_i,
  output logic [SLOTS-1:0]                          dep_o
);
  import fp_sa_pkg::*;

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    logic [NUM_SRC-1:0] hit;
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      assign hit[s] = src_vld_i[k][s] && (src_i[k][s] == tag_i);
    end
    assign dep_o[k] = open_i && (|hit);
  end
endmodule

// File: rtl/fp_sa_slot_stage.sv
module fp_sa_slot_stage #(
  parameter int unsigned SLOTS = 2,
  parameter int unsigned ID_W  = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [SLOTS-1:0]           iss_vld_i,
  input  logic [SLOTS-1:0][ID_W-1:0] iss_id_i,
  input  logic [SLOTS-1:0]           dep_i,
  input  logic                       ld_miss_i,
  output logic [SLOTS-1:0]           abort_o,
  output logic [SLOTS-1:0]           retire_o,
  output logic [SLOTS-1:0][ID_W-1:0] out_id_o
);
  logic [SLOTS-1:0]           vld_q;
  logic [SLOTS-1:0]           dep_q;
  logic [SLOTS-1:0][ID_W-1:0] id_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      dep_q <= '0;
      id_q  <= '0;
    end else begin
      vld_q <= iss_vld_i;
      dep_q <= dep_i & iss_vld_i;
      id_q  <= iss_id_i;
    end
  end

  // dep_q is only ever set for window issues, so a stray miss is inert
  for (genvar k = 0; k < SLOTS; k++) begin : g_out
    logic kill;
    assign kill        = dep_q[k] && ld_miss_i;
    assign abort_o[k]  = vld_q[k] && kill;
    assign retire_o[k] = vld_q[k] && !kill;
    assign out_id_o[k] = id_q[k];
  end
endmodule

// File: rtl/fp_sa_reissue.sv
module fp_sa_reissue #(
  parameter int unsigned SLOTS   = 2,
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned ID_W    = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [SLOTS-1:0]           abort_i,
  input  logic [SLOTS-1:0][ID_W-1:0] id_i,
  output logic [ENTRIES-1:0]         reissue_o
);
  logic [ENTRIES-1:0] mask_d;
  logic [ENTRIES-1:0] mask_q;

  always_comb begin
    mask_d = '0;
    for (int k = 0; k < SLOTS; k++) begin
      if (abort_i[k]) mask_d[id_i[k]] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q <= '0;
    else         mask_q <= mask_d;
  end

  assign reissue_o = mask_q;
endmodule

// File: rtl/fp_sel_abort.sv
module fp_sel_abort #(
  parameter int unsigned SLOTS    = 2,
  parameter int unsigned ENTRIES  = 16,
  parameter int unsigned TAG_W    = 6,
  parameter int unsigned LOAD_LAT = 4,
  localparam int unsigned ID_W    = $clog2(ENTRIES),
  localparam int unsigned NSRC    = fp_sa_pkg::NUM_SRC
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 ld_issue_i,
  input  logic [TAG_W-1:0]                     ld_dst_i,
  input  logic                                 ld_miss_i,
  input  logic [SLOTS-1:0]                     iss_vld_i,
  input  logic [SLOTS-1:0][ID_W-1:0]           iss_id_i,
  input  logic [SLOTS-1:0][NSRC-1:0][TAG_W-1:0] iss_src_i,
  input  logic [SLOTS-1:0][NSRC-1:0]           iss_src_vld_i,
  output logic [SLOTS-1:0]                     abort_o,
  output logic [SLOTS-1:0]                     retire_o,
  output logic [SLOTS-1:0][ID_W-1:0]           out_id_o,
  output logic [ENTRIES-1:0]                   reissue_o
);
  logic             win_open;
  logic [TAG_W-1:0] win_tag;
  logic [SLOTS-1:0] dep;

  fp_sa_tracker #(.TAG_W(TAG_W), .LOAD_LAT(LOAD_LAT)) u_tracker (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ld_issue_i (ld_issue_i),
    .ld_dst_i   (ld_dst_i),
    .win_open_o (win_open),
    .win_tag_o  (win_tag)
  );

  fp_sa_dep_match #(.SLOTS(SLOTS), .TAG_W(TAG_W)) u_match (
    .open_i    (win_open),
    .tag_i     (win_tag),
    .src_i     (iss_src_i),
    .src_vld_i (iss_src_vld_i),
    .dep_o     (dep)
  );

  fp_sa_slot_stage #(.SLOTS(SLOTS), .ID_W(ID_W)) u_stage (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .iss_vld_i (iss_vld_i),
    .iss_id_i  (iss_id_i),
    .dep_i     (dep),
    .ld_miss_i (ld_miss_i),
    .abort_o   (abort_o),
    .retire_o  (retire_o),
    .out_id_o  (out_id_o)
  );

  fp_sa_reissue #(.SLOTS(SLOTS), .ENTRIES(ENTRIES), .ID_W(ID_W)) u_reissue (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .abort_i   (abort_o),
    .id_i      (out_id_o),
    .reissue_o (reissue_o)
  );
endmodule

// File: rtl/fp_sel_abort_chk.sv
module fp_sel_abort_chk #(
  parameter int unsigned SLOTS    = 2,
  parameter int unsigned ENTRIES  = 16,
  parameter int unsigned LOAD_LAT = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               ld_issue_i,
  input logic               ld_miss_i,
  input logic               win_open_i,
  input logic [SLOTS-1:0]   iss_vld_i,
  input logic [SLOTS-1:0]   abort_o,
  input logic [SLOTS-1:0]   retire_o,
  input logic [ENTRIES-1:0] reissue_o
);
  localparam int unsigned CW = $clog2(LOAD_LAT + 1);
  localparam logic [CW-1:0] CMAX = CW'(LOAD_LAT);
  localparam logic [CW-1:0] CWIN = CW'(LOAD_LAT - 1);

  // cycles since the most recent load, saturating
  logic [CW-1:0] since_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              since_q <= CMAX;
    else if (ld_issue_i)      since_q <= CW'(1);
    else if (since_q != CMAX) since_q <= since_q + CW'(1);
  end

  AST_WINDOW_TIMING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_open_i == (since_q == CWIN)); // R9

  AST_REISSUE_AFTER_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reissue_o != '0) |-> $past(abort_o != '0)); // R8

  AST_REISSUE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(reissue_o) <= SLOTS); // R8

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    AST_ONE_OUTCOME: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (abort_o[k] || retire_o[k]) == $past(iss_vld_i[k])); // R7

    AST_EXCL_OUTCOME: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(abort_o[k] && retire_o[k])); // R7

    AST_ABORT_IN_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      abort_o[k] |-> $past(win_open_i)); // R2

    AST_ABORT_NEEDS_MISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      abort_o[k] |-> ld_miss_i); // R3
  end
endmodule

bind fp_sel_abort fp_sel_abort_chk #(
  .SLOTS(SLOTS), .ENTRIES(ENTRIES), .LOAD_LAT(LOAD_LAT)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ld_issue_i (ld_issue_i),
  .ld_miss_i  (ld_miss_i),
  .win_open_i (win_open),
  .iss_vld_i  (iss_vld_i),
  .abort_o    (abort_o),
  .retire_o   (retire_o),
  .reissue_o  (reissue_o)
);

// File: tb/fp_sel_abort_bench.sv
module fp_sel_abort_bench;
  localparam int unsigned SLOTS = 2, ENTRIES = 16, TAG_W = 6, ID_W = 4;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic ld_issue = 1'b0, ld_miss = 1'b0;
  logic [TAG_W-1:0] ld_dst = '0;
  logic [SLOTS-1:0] iss_vld = '0;
  logic [SLOTS-1:0][ID_W-1:0] iss_id = '0;
  logic [SLOTS-1:0][1:0][TAG_W-1:0] iss_src = '0;
  logic [SLOTS-1:0][1:0] iss_src_vld = '0;
  logic [SLOTS-1:0] abort_o, retire_o;
  logic [SLOTS-1:0][ID_W-1:0] out_id;
  logic [ENTRIES-1:0] reissue;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  fp_sel_abort u_fp_sel_abort (
    .clk_i(clk), .rst_ni(rst_ni), .ld_issue_i(ld_issue), .ld_dst_i(ld_dst),
    .ld_miss_i(ld_miss), .iss_vld_i(iss_vld), .iss_id_i(iss_id),
    .iss_src_i(iss_src), .iss_src_vld_i(iss_src_vld), .abort_o(abort_o),
    .retire_o(retire_o), .out_id_o(out_id), .reissue_o(reissue)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic issue_load(logic [TAG_W-1:0] tag);
    ld_issue = 1'b1; ld_dst = tag;
    cyc();
    ld_issue = 1'b0;
  endtask

  // sv bits: {s1 op1, s1 op0, s0 op1, s0 op0}
  task automatic set_slots(logic [1:0] vld, logic [5:0] a0, logic [5:0] b0,
                           logic [5:0] a1, logic [5:0] b1, logic [3:0] sv,
                           logic [3:0] id0, logic [3:0] id1);
    iss_vld = vld;
    iss_src[0][0] = a0; iss_src[0][1] = b0;
    iss_src[1][0] = a1; iss_src[1][1] = b1;
    iss_src_vld[0] = sv[1:0]; iss_src_vld[1] = sv[3:2];
    iss_id[0] = id0; iss_id[1] = id1;
  endtask

  task automatic clr_slots();
    iss_vld = '0; iss_src_vld = '0;
  endtask

  // load at N0, window at N3, decision at N4, reissue at N5
  task automatic win_case(string req, logic [5:0] tag, logic [1:0] vld,
                          logic [5:0] a0, logic [5:0] b0, logic [5:0] a1,
                          logic [5:0] b1, logic [3:0] sv, logic [3:0] id0,
                          logic [3:0] id1, logic miss, logic [1:0] ea,
                          logic [1:0] er);
    logic [ENTRIES-1:0] exp_mask;
    exp_mask = '0;
    if (ea[0]) exp_mask[id0] = 1'b1;
    if (ea[1]) exp_mask[id1] = 1'b1;
    issue_load(tag);
    cyc(); cyc();
    set_slots(vld, a0, b0, a1, b1, sv, id0, id1);
    cyc();
    clr_slots(); ld_miss = miss;
    #1;
    chk({req, " abort"}, 32'(abort_o), 32'(ea));
    chk({req, " retire"}, 32'(retire_o), 32'(er));
    if (vld[0]) chk({req, " R7 id0"}, 32'(out_id[0]), 32'(id0));
    if (vld[1]) chk({req, " R7 id1"}, 32'(out_id[1]), 32'(id1));
    cyc();
    ld_miss = 1'b0;
    #1;
    chk({req, " R8 reissue"}, 32'(reissue), 32'(exp_mask));
    cyc();
    chk({req, " R8 reissue one cycle"}, 32'(reissue), 32'h0);
  endtask

  task automatic t_reset();
    chk("R1 abort in reset", 32'(abort_o), 0);
    chk("R1 retire in reset", 32'(retire_o), 0);
    chk("R1 reissue in reset", 32'(reissue), 0);
    cyc(); rst_ni = 1'b1; #1;
    chk("R1 abort after reset", 32'(abort_o), 0);
    chk("R1 retire after reset", 32'(retire_o), 0);
  endtask

  task automatic t_hit();
    win_case("R5 hit", 6'd12, 2'b11, 6'd12, 6'd1, 6'd2, 6'd12, 4'b1111,
             4'd3, 4'd4, 1'b0, 2'b00, 2'b11);
  endtask

  task automatic t_miss_mixed();
    // slot0 reads the load, slot1 is independent
    win_case("R3 R4 miss mixed", 6'd20, 2'b11, 6'd20, 6'd5, 6'd6, 6'd7,
             4'b1111, 4'd9, 4'd10, 1'b1, 2'b01, 2'b10);
  endtask

  task automatic t_second_operand();
    // slot0 match on an invalid operand; slot1 match on operand 1
    win_case("R6 operand select", 6'd33, 2'b11, 6'd33, 6'd33, 6'd1, 6'd33,
             4'b1000, 4'd2, 4'd15, 1'b1, 2'b10, 2'b01);
  endtask

  task automatic t_both_abort();
    win_case("R3 both abort", 6'd40, 2'b11, 6'd40, 6'd0, 6'd0, 6'd40,
             4'b1111, 4'd0, 4'd7, 1'b1, 2'b11, 2'b00);
  endtask

  task automatic t_empty_window();
    win_case("R7 empty window", 6'd41, 2'b00, 6'd41, 6'd41, 6'd41, 6'd41,
             4'b1111, 4'd1, 4'd2, 1'b1, 2'b00, 2'b00);
  endtask

  task automatic t_outside();
    issue_load(6'd5);                       // now N1
    cyc();                                  // N2: not the window
    set_slots(2'b01, 6'd5, 6'd5, 6'd0, 6'd0, 4'b0011, 4'd6, 4'd0);
    cyc();                                  // N3: window opens, nothing issued
    clr_slots(); ld_miss = 1'b1; #1;
    chk("R2 early issue retires", 32'(retire_o), 32'h1);
    chk("R10 early issue not aborted", 32'(abort_o), 32'h0);
    cyc();                                  // N4: resolution, empty
    set_slots(2'b01, 6'd5, 6'd5, 6'd0, 6'd0, 4'b0011, 4'd8, 4'd0);
    #1;
    chk("R10 miss no issue", 32'(abort_o | retire_o), 32'h0);
    cyc();                                  // N5: decision on late issue
    clr_slots(); #1;
    chk("R2 late issue retires", 32'(retire_o), 32'h1);
    chk("R10 late issue not aborted", 32'(abort_o), 32'h0);
    cyc(); ld_miss = 1'b0; #1;
    chk("R10 no reissue", 32'(reissue), 32'h0);
  endtask

  task automatic t_overwrite();
    issue_load(6'd7);                       // N1
    cyc();                                  // N2
    issue_load(6'd9);                       // N3: old window cancelled
    set_slots(2'b11, 6'd7, 6'd0, 6'd9, 6'd0, 4'b0101, 4'd1, 4'd2);
    cyc();                                  // N4
    clr_slots(); ld_miss = 1'b1; #1;
    chk("R9 old window gone", 32'(abort_o), 32'h0);
    chk("R9 old window retire", 32'(retire_o), 32'h3);
    ld_miss = 1'b0;
    cyc();                                  // N5: new window
    set_slots(2'b11, 6'd7, 6'd0, 6'd9, 6'd0, 4'b0101, 4'd11, 4'd12);
    cyc();                                  // N6
    clr_slots(); ld_miss = 1'b1; #1;
    chk("R9 new tag abort", 32'(abort_o), 32'h2);
    chk("R9 old tag retires", 32'(retire_o), 32'h1);
    cyc(); ld_miss = 1'b0; #1;
    chk("R9 R8 reissue", 32'(reissue), 32'h1000);
  endtask

  initial begin
    repeat (3) cyc();
    t_reset();
    cyc();
    t_hit();
    t_miss_mixed();
    t_second_operand();
    t_both_abort();
    t_empty_window();
    t_outside();
    repeat (4) cyc();
    t_overwrite();
    repeat (2) cyc();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule